// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Read Path

This block models the read side of a pipelined synchronous SRAM whose data output runs at double data rate. On each rising edge of the input clock it looks at a read/write select, an active-low load strobe and an address. A read request is that select high with the strobe low. The block takes the address as the base of a four-word burst. The two low address bits seed a burst counter that walks through the aligned group of four words and wraps within that group.

Each accepted read returns four words over two clock cycles. The two output phases of a cycle are shown as a pair of word outputs: phase 0 is the word on the rising edge of the output clock, and phase 1 is the word on the edge of its complement. Each phase has a valid flag, and an output-enable shows when the bus is driven. A request on the edge right after an accepted read is dropped. Requests on alternate edges keep the bus busy with no gaps. When reads stop, the pending words are delivered and the outputs then float. A single-word write port preloads the array. It is not part of the read protocol.

Top module: `ddr_burst_rd`

## Requirements
- R1: While reset is held and after it is released with no request, oe, vld_ph0 and vld_ph1 are 0, and q_ph0 and q_ph1 read 0 (floating).
- R2: A request is rd_sel=1 with ld_n=0 sampled at rising edge n. After edge n+1, q_ph0 and q_ph1 carry burst words 0 and 1. After edge n+2 they carry words 2 and 3. In both cycles oe, vld_ph0 and vld_ph1 are 1.
- R3: For base address A, burst word k (k = 0..3) comes from address {A[AW-1:2], (A[1:0]+k) mod 4}, so the burst wraps inside its aligned group of four.
- R4: A request sampled on the edge right after an accepted request is dropped. It produces no output words and never raises the valid flags.
- R5: Requests two edges apart are all accepted, and their bursts follow one another with oe and both valid flags high in every cycle and no idle cycle between them. This also holds when a dropped request lies between the two.
- R6: With rd_sel=0 or ld_n=1 at an edge, no burst starts. A write command (rd_sel=0, ld_n=0) on the read port is ignored.
- R7: After the last word pair of the last pending burst, oe, vld_ph0 and vld_ph1 go to 0 at the next edge, and the data outputs read 0.
- R8: wr_en=1 at an edge stores wr_data at wr_addr. A later burst reads that value back. A write has no effect on the read outputs.
- R9: Synchronous reset in the middle of a burst ends it. After the reset edge the outputs are off, and the remaining words are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 1 | Read/write select, 1 = read |
| ld_n | input | 1 | Active-low load strobe |
| addr | input | AW | Burst base address |
| wr_en | input | 1 | Preload write enable |
| wr_addr | input | AW | Preload write address |
| wr_data | input | DW | Preload write data |
| q_ph0 | output | DW | Word on the first output phase of the cycle |
| q_ph1 | output | DW | Word on the second output phase of the cycle |
| vld_ph0 | output | 1 | Phase 0 word valid |
| vld_ph1 | output | 1 | Phase 1 word valid |
| oe | output | 1 | Data outputs driven (0 = floating) |

## Verification
The hardest case to reach from the ports is a request on the edge just after an accepted read, followed at once by a legal request on the next edge. The first must vanish while the second streams with no gap behind the first burst. The bench drives requests on three consecutive edges with distinct base addresses. It then checks, pair by pair, that exactly the first and third bursts appear back to back, followed by an idle bus. A reset asserted between the two word pairs of a burst covers the abort path.

// File: rtl/ddr_burst_rd_pkg.sv
package ddr_burst_rd_pkg;
  localparam int BURST_WORDS = 4;
  localparam int OFS_W       = $clog2(BURST_WORDS);

  // Linear burst step, wrapping inside the aligned group of four.
  function automatic logic [OFS_W-1:0] burst_ofs(input logic [OFS_W-1:0] seed,
                                                 input logic [OFS_W-1:0] step);
    return seed + step;
  endfunction
endpackage

// File: rtl/ddr_burst_store.sv
module ddr_burst_store #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/ddr_burst_ctl.sv
module ddr_burst_ctl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_sel,
  input  logic          ld_n,
  input  logic [AW-1:0] addr,
  output logic          accept,
  output logic          act,
  output logic          beat,
  output logic [AW-1:0] base
);
  logic req;
  logic acc_q;

  assign req    = rd_sel && !ld_n;
  assign accept = req && !acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 1'b0;
      act   <= 1'b0;
      beat  <= 1'b0;
      base  <= '0;
    end else begin
      acc_q <= accept;
      if (accept) begin
        base <= addr;
        beat <= 1'b0;
        act  <= 1'b1;
      end else if (act && !beat) begin
        beat <= 1'b1;
      end else begin
        act  <= 1'b0;
        beat <= 1'b0;
      end
    end
  end

  AST_DROP_NEXT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept); // R4

  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (rst)
    (act && !beat) |=> (act && beat)); // R2
endmodule

// File: rtl/ddr_burst_out.sv
module ddr_burst_out #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act,
  input  logic [DW-1:0] w0,
  input  logic [DW-1:0] w1,
  output logic [DW-1:0] q_ph0,
  output logic [DW-1:0] q_ph1,
  output logic          vld_ph0,
  output logic          vld_ph1,
  output logic          oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_ph0   <= '0;
      q_ph1   <= '0;
      vld_ph0 <= 1'b0;
      vld_ph1 <= 1'b0;
      oe      <= 1'b0;
    end else begin
      q_ph0   <= act ? w0 : '0;
      q_ph1   <= act ? w1 : '0;
      vld_ph0 <= act;
      vld_ph1 <= act;
      oe      <= act;
    end
  end

  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (q_ph0 == '0 && q_ph1 == '0)); // R7
endmodule

// File: rtl/ddr_burst_rd.sv
module ddr_burst_rd
  import ddr_burst_rd_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_sel,
  input  logic          ld_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] q_ph0,
  output logic [DW-1:0] q_ph1,
  output logic          vld_ph0,
  output logic          vld_ph1,
  output logic          oe
);
  logic          accept;
  logic          act;
  logic          beat;
  logic [AW-1:0] base;
  logic [AW-1:0] ra0;
  logic [AW-1:0] ra1;
  logic [DW-1:0] rd0;
  logic [DW-1:0] rd1;

  ddr_burst_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .ld_n(ld_n), .addr(addr),
    .accept(accept), .act(act), .beat(beat), .base(base)
  );

  assign ra0 = {base[AW-1:OFS_W], burst_ofs(base[OFS_W-1:0], {beat, 1'b0})};
  assign ra1 = {base[AW-1:OFS_W], burst_ofs(base[OFS_W-1:0], {beat, 1'b1})};

  ddr_burst_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ra0(ra0), .ra1(ra1), .rd0(rd0), .rd1(rd1)
  );

  ddr_burst_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .act(act), .w0(rd0), .w1(rd1),
    .q_ph0(q_ph0), .q_ph1(q_ph1), .vld_ph0(vld_ph0), .vld_ph1(vld_ph1), .oe(oe)
  );

  AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 (oe && vld_ph0 && vld_ph1)); // R2

  AST_BURST_SPAN: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |=> oe); // R5

  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (oe && !act) |=> !oe); // R7

  AST_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!accept && !act) |=> ##1 !vld_ph0); // R6

  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (!oe && !vld_ph0 && !vld_ph1)); // R9
endmodule

// File: tb/tb_ddr_burst_rd.sv
module tb_ddr_burst_rd;
  localparam int AW = 8;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_sel = 1'b0;
  logic          ld_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] q_ph0, q_ph1;
  logic          vld_ph0, vld_ph1, oe;

  logic [DW-1:0] model [DEPTH];
  int tests = 0;
  int fails = 0;

  ddr_burst_rd #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .ld_n(ld_n), .addr(addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_ph0(q_ph0), .q_ph1(q_ph1), .vld_ph0(vld_ph0), .vld_ph1(vld_ph1), .oe(oe)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] a, input int k);
    int lo;
    lo = (int'(a) + k) % 4;
    return (a & ~AW'(3)) | AW'(lo);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act_v,
                     input logic [63:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic check_off(input string tag);
    chk(!oe && !vld_ph0 && !vld_ph1 && q_ph0 == '0 && q_ph1 == '0, tag,
        {oe, vld_ph0, vld_ph1, q_ph0, q_ph1}, 64'h0);
  endtask

  task automatic check_pair(input logic [AW-1:0] a, input int bt, input string tag);
    logic [DW-1:0] e0, e1;
    e0 = model[word_addr(a, 2*bt)];
    e1 = model[word_addr(a, 2*bt+1)];
    chk(oe && vld_ph0 && vld_ph1, {tag, " flags"}, {oe, vld_ph0, vld_ph1}, 3'b111);
    chk(q_ph0 == e0, {tag, " ph0"}, q_ph0, e0);
    chk(q_ph1 == e1, {tag, " ph1"}, q_ph1, e1);
  endtask

  task automatic drive_req(input logic [AW-1:0] a);
    rd_sel = 1'b1; ld_n = 1'b0; addr = a;
  endtask

  task automatic drive_idle();
    rd_sel = 1'b0; ld_n = 1'b1; addr = '0;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_off("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_off("R1 after reset");
  endtask

  task automatic t_single(input logic [AW-1:0] a, input string tag);
    drive_req(a);
    @(negedge clk); drive_idle();
    check_off({tag, " before first pair"});
    @(negedge clk); check_pair(a, 0, {tag, " pair0"});
    @(negedge clk); check_pair(a, 1, {tag, " pair1"});
    @(negedge clk); check_off("R7 deselect after burst");
  endtask

  task automatic t_drop();
    drive_req(8'h20);
    @(negedge clk); drive_req(8'h44);
    @(negedge clk); drive_idle(); check_pair(8'h20, 0, "R4 kept pair0");
    @(negedge clk); check_pair(8'h20, 1, "R4 kept pair1");
    @(negedge clk); check_off("R4 dropped request gives no words");
    @(negedge clk); check_off("R4 still idle");
  endtask

  task automatic t_stream();
    drive_req(8'h30);
    @(negedge clk); drive_idle();
    @(negedge clk); check_pair(8'h30, 0, "R5 a0"); drive_req(8'h65);
    @(negedge clk); check_pair(8'h30, 1, "R5 a1"); drive_idle();
    @(negedge clk); check_pair(8'h65, 0, "R5 b0"); drive_req(8'h9A);
    @(negedge clk); check_pair(8'h65, 1, "R5 b1"); drive_idle();
    @(negedge clk); check_pair(8'h9A, 0, "R5 c0");
    @(negedge clk); check_pair(8'h9A, 1, "R5 c1");
    @(negedge clk); check_off("R7 after stream");
  endtask

  task automatic t_triple();
    drive_req(8'h11);
    @(negedge clk); drive_req(8'h77);
    @(negedge clk); check_pair(8'h11, 0, "R5 triple a0"); drive_req(8'hC2);
    @(negedge clk); check_pair(8'h11, 1, "R5 triple a1"); drive_idle();
    @(negedge clk); check_pair(8'hC2, 0, "R5 triple c0 after drop");
    @(negedge clk); check_pair(8'hC2, 1, "R5 triple c1");
    @(negedge clk); check_off("R4 middle request never appears");
  endtask

  task automatic t_ignore();
    rd_sel = 1'b0; ld_n = 1'b0; addr = 8'h50;
    @(negedge clk); drive_idle();
    repeat (3) begin
      @(negedge clk); check_off("R6 write command ignored");
    end
    rd_sel = 1'b1; ld_n = 1'b1; addr = 8'h50;
    @(negedge clk); drive_idle();
    repeat (3) begin
      @(negedge clk); check_off("R6 strobe high ignored");
    end
  endtask

  task automatic t_write();
    write_word(8'h55, 18'h2A5A5);
    check_off("R8 write leaves outputs off");
    @(negedge clk); check_off("R8 write leaves outputs off next");
    t_single(8'h55, "R8 readback");
  endtask

  task automatic t_reset_mid();
    drive_req(8'h84);
    @(negedge clk); drive_idle();
    @(negedge clk); check_pair(8'h84, 0, "R9 pair0 before reset");
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; check_off("R9 reset ends burst");
    @(negedge clk); check_off("R9 no remaining words");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = DW'((i * 37 + 5) ^ (i << 9));
    @(negedge clk);
    t_reset();
    for (int i = 0; i < DEPTH; i++) write_word(AW'(i), model[i]);
    t_single(8'h10, "R2 aligned burst");
    t_single(8'h13, "R3 wrap from offset 3");
    t_single(8'h2E, "R3 wrap from offset 2");
    t_single(8'hF1, "R3 wrap from offset 1");
    t_drop();
    t_stream();
    t_triple();
    t_ignore();
    t_write();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule